// File: doc/BRIEF.md
# RTC Alarm Match Interrupt

This block sits beside the timekeeping counters of a real-time clock. It compares the current time with two alarm settings and drives one active-low interrupt line for each. The weekly alarm matches on hour, minute and a set of weekdays. The daily alarm matches on hour and minute on every day. Minutes and hours arrive in BCD and are compared as raw bytes. The counters issue a one-cycle `min_tick` strobe in the same cycle that they present a new minute value. The block evaluates the alarm comparison only on that strobe.

A host configures the block through a small register port. It has a write strobe with an address and data, and a combinational read path. Register addresses:

| Address | Contents |
| --- | --- |
| 0 | Weekly minute |
| 1 | Weekly hour |
| 2 | Weekly weekday mask |
| 3 | Daily minute |
| 4 | Daily hour |
| 5 | Control |

The control register holds one enable bit and one flag bit for each alarm. A flag is cleared by writing 0 to it, and writing 1 to it does nothing. Clearing a flag leaves the alarm armed.

Each alarm channel is a three-state machine:

| State | Meaning |
| --- | --- |
| `CH_OFF` | Disabled |
| `CH_ARMED` | Enabled, waiting for a match |
| `CH_FIRED` | Flag set, interrupt low |

Transitions:

| Transition | From | To | Cause |
| --- | --- | --- | --- |
| arm | `CH_OFF` | `CH_ARMED` | A control write with the enable bit at 1 |
| disarm | `CH_ARMED` or `CH_FIRED` | `CH_OFF` | A control write with the enable bit at 0 |
| fire | `CH_ARMED` | `CH_FIRED` | A minute strobe on which the match is true and was false at the previous strobe |
| acknowledge | `CH_FIRED` | `CH_ARMED` | A control write with the enable bit at 1 and the flag bit at 0 |

If fire and acknowledge fall in the same cycle in `CH_ARMED`, fire wins, so a new event is never lost.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset both interrupt outputs are high, the control register reads 0x00, and every alarm register reads 0x00.
- R2: A write to addresses 0 to 4 stores the data byte. Reading the same address returns it combinationally on `rd_data`. The weekday mask uses bit d for weekday value d (0 to 6).
- R3: The control register layout is: bit 0 weekly enable, bit 1 daily enable, bit 2 weekly flag, bit 3 daily flag. Bits 7 to 4 read as 0. A control write that has an enable bit at 1 arms that alarm.
- R4: The weekly alarm matches when `cur_min` equals the weekly minute, `cur_hour` equals the weekly hour, and the mask bit selected by `cur_wday` is set. A mask with several bits set matches on each of those weekdays.
- R5: The daily alarm matches on minute and hour alone, on any weekday.
- R6: On a `min_tick` cycle where an enabled alarm's match is true, and was false at the previous `min_tick`, the flag sets. The interrupt output goes low at the same clock edge, and the flag bit reads 1 whenever that output is low.
- R7: A fired interrupt stays low over later minute strobes, including non-matching ones, until its flag or its enable is cleared.
- R8: Writing 1 to a flag bit has no effect. Writing 0 to a set flag clears it and raises the interrupt output. This leaves the enable bit at 1, and the alarm fires again at its next match.
- R9: Writing 0 to an enable bit clears that alarm's flag and raises its interrupt. A disabled alarm never sets its flag.
- R10: An alarm never fires twice within one matching interval. Clearing the flag while the time still matches does not re-set it. A strobe whose match was already true at the previous strobe does not set it, and neither does enabling during a match.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| min_tick | input | 1 | One-cycle strobe for a new minute value |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_wday | input | 3 | Current weekday, 0 to 6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_wk_n | output | 1 | Weekly alarm interrupt, active low |
| irq_dy_n | output | 1 | Daily alarm interrupt, active low |

## Verification
The bench covers the following corner cases, each with the failure it would expose:

- **Acknowledge inside a matching minute, then a repeated strobe with the same time.** An edge detector that was really a level check would assert the interrupt a second time.
- **Enabling an alarm while its time already matches.** A design that fires on arming would interrupt at once.
- **Writing 1 to a set flag.** A design that toggles or rewrites the flag would drop the interrupt.
- **Clearing a flag.** A design that cleared the enable along with the flag would never fire again.
- **Weekday mask with several bits set, and a right time on an unselected weekday.** A wrong day decode would either miss the selected days or fire on the wrong weekday.
- **Daily alarm on arbitrary weekdays.** A daily alarm that compared the weekday would fail to fire on some days.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_DAYS = 7;
    localparam int WDAY_W = $clog2(NUM_DAYS);

    typedef enum logic [ADDR_W-1:0] {
        REG_WK_MIN  = 3'd0,
        REG_WK_HOUR = 3'd1,
        REG_WK_DAYS = 3'd2,
        REG_DY_MIN  = 3'd3,
        REG_DY_HOUR = 3'd4,
        REG_CTRL    = 3'd5
    } reg_addr_e;

    localparam int CTL_WK_EN = 0;
    localparam int CTL_DY_EN = 1;
    localparam int CTL_WK_FL = 2;
    localparam int CTL_DY_FL = 3;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_FIRED = 2'd2
    } chan_state_e;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int ND = NUM_DAYS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] ctrl_view,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] wk_min,
    output logic [DW-1:0] wk_hour,
    output logic [ND-1:0] wk_days,
    output logic [DW-1:0] dy_min,
    output logic [DW-1:0] dy_hour
);
    localparam int PAD_W = DW - ND;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_min  <= '0;
            wk_hour <= '0;
            wk_days <= '0;
            dy_min  <= '0;
            dy_hour <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_WK_MIN:  wk_min  <= wr_data;
                REG_WK_HOUR: wk_hour <= wr_data;
                REG_WK_DAYS: wk_days <= wr_data[ND-1:0];
                REG_DY_MIN:  dy_min  <= wr_data;
                REG_DY_HOUR: dy_hour <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_addr)
            REG_WK_MIN:  rd_data = wk_min;
            REG_WK_HOUR: rd_data = wk_hour;
            REG_WK_DAYS: rd_data = {{PAD_W{1'b0}}, wk_days};
            REG_DY_MIN:  rd_data = dy_min;
            REG_DY_HOUR: rd_data = dy_hour;
            REG_CTRL:    rd_data = ctrl_view;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int ND = NUM_DAYS,
    parameter int WW = WDAY_W,
    parameter bit CHECK_DAY = 1'b1
) (
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [WW-1:0] cur_wday,
    input  logic [DW-1:0] set_min,
    input  logic [DW-1:0] set_hour,
    input  logic [ND-1:0] set_days,
    output logic          match
);
    logic time_hit;
    logic day_hit;

    assign time_hit = (cur_min == set_min) && (cur_hour == set_hour);

    generate
        if (CHECK_DAY) begin : g_day
            logic [ND-1:0] day_vec;
            for (genvar d = 0; d < ND; d++) begin : g_bit
                assign day_vec[d] = set_days[d] && (cur_wday == WW'(d));
            end
            assign day_hit = |day_vec;
        end else begin : g_any
            logic unused_days;
            assign unused_days = ^{set_days, cur_wday};
            assign day_hit = 1'b1;
        end
    endgenerate

    assign match = time_hit && day_hit;
endmodule

// File: rtl/alarm_chan.sv
module alarm_chan
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic min_tick,
    input  logic match,
    input  logic ctl_we,
    input  logic en_val,
    input  logic flag_val,
    output logic en_o,
    output logic flag_o,
    output logic irq_n
);
    chan_state_e state_q, state_n;
    logic        match_prev;
    logic        rise;

    assign rise = min_tick && match && !match_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_prev <= 1'b0;
        end else if (min_tick) begin
            match_prev <= match;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (ctl_we && en_val) state_n = CH_ARMED;
            end
            CH_ARMED: begin
                if (ctl_we && !en_val) state_n = CH_OFF;
                else if (rise)         state_n = CH_FIRED;
            end
            CH_FIRED: begin
                if (ctl_we && !en_val)        state_n = CH_OFF;
                else if (ctl_we && !flag_val) state_n = CH_ARMED;
            end
            default: state_n = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_n;
    end

    always_comb begin
        en_o   = (state_q != CH_OFF);
        flag_o = (state_q == CH_FIRED);
        irq_n  = (state_q != CH_FIRED);
    end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int ND = NUM_DAYS,
    parameter int WW = WDAY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          min_tick,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [WW-1:0] cur_wday,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq_wk_n,
    output logic          irq_dy_n
);
    localparam int CTL_USED = 4;

    logic [DW-1:0] wk_min, wk_hour, dy_min, dy_hour;
    logic [ND-1:0] wk_days;
    logic          wk_match, dy_match;
    logic          wk_en, wk_flag, dy_en, dy_flag;
    logic          ctl_we;
    logic [DW-1:0] ctrl_view;

    assign ctl_we = wr_en && (wr_addr == REG_CTRL);

    always_comb begin
        ctrl_view = '0;
        ctrl_view[CTL_WK_EN] = wk_en;
        ctrl_view[CTL_DY_EN] = dy_en;
        ctrl_view[CTL_WK_FL] = wk_flag;
        ctrl_view[CTL_DY_FL] = dy_flag;
    end

    alarm_regs #(.DW(DW), .AW(AW), .ND(ND)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .ctrl_view(ctrl_view), .rd_data(rd_data),
        .wk_min(wk_min), .wk_hour(wk_hour), .wk_days(wk_days),
        .dy_min(dy_min), .dy_hour(dy_hour)
    );

    alarm_cmp #(.DW(DW), .ND(ND), .WW(WW), .CHECK_DAY(1'b1)) i_cmp_wk (
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
        .set_min(wk_min), .set_hour(wk_hour), .set_days(wk_days),
        .match(wk_match)
    );

    alarm_cmp #(.DW(DW), .ND(ND), .WW(WW), .CHECK_DAY(1'b0)) i_cmp_dy (
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
        .set_min(dy_min), .set_hour(dy_hour), .set_days({ND{1'b0}}),
        .match(dy_match)
    );

    alarm_chan i_chan_wk (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .match(wk_match),
        .ctl_we(ctl_we), .en_val(wr_data[CTL_WK_EN]), .flag_val(wr_data[CTL_WK_FL]),
        .en_o(wk_en), .flag_o(wk_flag), .irq_n(irq_wk_n)
    );

    alarm_chan i_chan_dy (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .match(dy_match),
        .ctl_we(ctl_we), .en_val(wr_data[CTL_DY_EN]), .flag_val(wr_data[CTL_DY_FL]),
        .en_o(dy_en), .flag_o(dy_flag), .irq_n(irq_dy_n)
    );

    logic unused_hi;
    assign unused_hi = ^wr_data[DW-1:CTL_USED];
endmodule

// File: rtl/alarm_irq_checker.sv
module alarm_irq_checker
    import alarm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          min_tick,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          irq_wk_n,
    input logic          irq_dy_n
);
    logic ctl_wr;
    assign ctl_wr = wr_en && (wr_addr == REG_CTRL);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_high_R1: assert (irq_wk_n && irq_dy_n);
        end
    end

    assert_fire_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_wk_n) |-> $past(min_tick));
    assert_fire_on_tick_dy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_dy_n) |-> $past(min_tick));

    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_wk_n && !ctl_wr) |=> !irq_wk_n);
    assert_hold_low_dy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_dy_n && !ctl_wr) |=> !irq_dy_n);

    assert_clear_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_data[CTL_WK_FL] && !min_tick) |=> irq_wk_n);
    assert_clear_releases_dy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_data[CTL_DY_FL] && !min_tick) |=> irq_dy_n);

    assert_disable_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_data[CTL_WK_EN]) |=> irq_wk_n);
    assert_disable_releases_dy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_data[CTL_DY_EN]) |=> irq_dy_n);
endmodule

bind alarm_irq_unit alarm_irq_checker #(.DW(DW), .AW(AW)) i_checker (
    .clk(clk), .rst_n(rst_n), .min_tick(min_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_wk_n(irq_wk_n), .irq_dy_n(irq_dy_n)
);

// File: tb/test_alarm_irq_unit.sv
module test_alarm_irq_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       min_tick = 1'b0;
    logic [7:0] cur_min = 8'h00;
    logic [7:0] cur_hour = 8'h00;
    logic [2:0] cur_wday = 3'd0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd5;
    logic [7:0] rd_data;
    logic       irq_wk_n, irq_dy_n;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [9:0] exp_q[$];
    string      req_q[$];
    event       chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_irq_unit i_alarm_irq_unit (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_wk_n(irq_wk_n), .irq_dy_n(irq_dy_n)
    );

    // monitor: pops expected {irq_dy_n, irq_wk_n, ctrl} and compares
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                logic [9:0] e;
                string r;
                logic [9:0] a;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                a = {irq_dy_n, irq_wk_n, rd_data};
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s: irq_dy_n,irq_wk_n,ctrl actual=%b_%b_%h expected=%b_%b_%h",
                             r, a[9], a[8], a[7:0], e[9], e[8], e[7:0]);
                end
            end
        end
    end

    task automatic expect_now(input logic [1:0] irq, input logic [7:0] ctrl, input string r);
        exp_q.push_back({irq, ctrl});
        req_q.push_back(r);
        ->chk_ev;
        #1;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic [7:0] m, input logic [7:0] h, input logic [2:0] wd);
        @(negedge clk);
        cur_min = m; cur_hour = h; cur_wday = wd; min_tick = 1'b1;
        @(negedge clk);
        min_tick = 1'b0;
    endtask

    task automatic direct_check(input logic [2:0] a, input logic [7:0] e, input string r);
        rd_addr = a;
        #1;
        total++;
        if (rd_data !== e) begin
            bad++;
            $display("FAIL %s: rd_data[%0d] actual=%h expected=%h", r, a, rd_data, e);
        end
        rd_addr = 3'd5;
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            #2;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_now(2'b11, 8'h00, "R1 reset");
        for (int a = 0; a < 5; a++) direct_check(3'(a), 8'h00, "R1 alarm regs");
        rst_n = 1'b1;

        // weekly 07:30 on weekday 1, daily 12:45
        reg_write(3'd0, 8'h30);
        reg_write(3'd1, 8'h07);
        reg_write(3'd2, 8'h02);
        reg_write(3'd3, 8'h45);
        reg_write(3'd4, 8'h12);
        direct_check(3'd2, 8'h02, "R2 mask readback");
        direct_check(3'd4, 8'h12, "R2 hour readback");
        reg_write(3'd5, 8'h0F);
        expect_now(2'b11, 8'h03, "R3 enables set, flag write 1 ignored");

        tick(8'h29, 8'h07, 3'd1);
        expect_now(2'b11, 8'h03, "R4 no match");
        tick(8'h30, 8'h07, 3'd1);
        expect_now(2'b10, 8'h07, "R6 weekly fires");
        reg_write(3'd5, 8'h0F);
        expect_now(2'b10, 8'h07, "R8 write 1 to set flag ignored");
        tick(8'h31, 8'h07, 3'd1);
        expect_now(2'b10, 8'h07, "R7 stays low");
        reg_write(3'd5, 8'h03);
        expect_now(2'b11, 8'h03, "R8 clear keeps enable");

        tick(8'h45, 8'h12, 3'd3);
        expect_now(2'b01, 8'h0B, "R5 daily fires on weekday 3");
        tick(8'h30, 8'h07, 3'd3);
        expect_now(2'b01, 8'h0B, "R4 unselected weekday");
        reg_write(3'd5, 8'h01);
        expect_now(2'b11, 8'h01, "R9 disable releases");
        tick(8'h45, 8'h12, 3'd1);
        expect_now(2'b11, 8'h01, "R9 disabled does not fire");

        reg_write(3'd5, 8'h03);
        expect_now(2'b11, 8'h03, "R10 enable during match");
        tick(8'h46, 8'h12, 3'd1);
        expect_now(2'b11, 8'h03, "R10 no fire after enable");
        tick(8'h45, 8'h12, 3'd6);
        expect_now(2'b01, 8'h0B, "R5 daily fires on weekday 6");
        reg_write(3'd5, 8'h03);
        repeat (3) @(negedge clk);
        expect_now(2'b11, 8'h03, "R10 cleared inside match");
        tick(8'h45, 8'h12, 3'd6);
        expect_now(2'b11, 8'h03, "R10 repeated match strobe");

        reg_write(3'd2, 8'h41);
        tick(8'h30, 8'h07, 3'd6);
        expect_now(2'b10, 8'h07, "R4 mask bit 6");
        reg_write(3'd5, 8'h03);
        tick(8'h31, 8'h07, 3'd6);
        expect_now(2'b11, 8'h03, "R8 cleared");
        tick(8'h30, 8'h07, 3'd0);
        expect_now(2'b10, 8'h07, "R8 fires again, mask bit 0");
        reg_write(3'd5, 8'h03);
        tick(8'h31, 8'h07, 3'd0);
        tick(8'h30, 8'h07, 3'd1);
        expect_now(2'b11, 8'h03, "R4 mask bit 1 clear");

        finish_run();
    end
endmodule